// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a synchronous I2C target. It samples SCL and SDA with the system clock, detects START and STOP, and shifts in a 7-bit address followed by a direction bit. The address is compared with a configured value. On a match the target acknowledges. It then either receives data bytes from the controller or sends data bytes to it, one byte at a time, until the controller ends the transfer.

Both bus lines are driven through active-high pull-down enables, and the external bus resistors supply the high level. The local logic sees a valid/ready byte port in each direction. When the local side is not ready, the target holds SCL low between bytes. When the local side reports that it is full, the target refuses a written byte by leaving SDA high on that byte's acknowledge clock.

Top module: `i2c_target`

## Requirements
- R1: SDA falling while SCL is high (START) begins a new address phase with the bit count cleared, including in the middle of a byte. SDA rising while SCL is high (STOP) returns the target to idle. Both release SCL and SDA.
- R2: The address byte is taken most significant bit first: 7 address bits, then a direction bit (0 = controller writes, 1 = controller reads). When the 7 bits equal own_addr_i, the target pulls SDA low for the whole ninth clock.
- R3: On an address mismatch the target does not pull SDA low on the ninth clock. Until the next START it pulls neither line low, presents no received byte and requests no transmit byte.
- R4: In a write, each data byte (MSB first) appears on rx_data_o with rx_valid_o high. SCL is held low from the falling edge after the eighth bit until rx_ready_i is accepted. The byte is then acknowledged with SDA low.
- R5: While rx_valid_o is high and rx_ready_i is low, rx_valid_o stays high and rx_data_o stays unchanged.
- R6: If rx_full_i is high at the falling edge after the eighth bit of a write data byte, the byte is not presented, SDA stays high on the ninth clock (NACK), and the target idles until the next START.
- R7: In a read, after the address acknowledge and after each controller ACK, SCL is held low with tx_ready_o high until tx_valid_i is high. That byte is then sent MSB first.
- R8: A controller NACK (SDA high on the ninth clock of a read byte) ends the read. The target releases SDA and requests no further byte until the next START.
- R9: The target changes its SDA pull-down only while SCL is low, and it starts stretching SCL only while SCL is already low.
- R10: A transfer may hold any number of bytes. A repeated START without STOP begins a fresh address phase, so the direction can change.
- R11: After reset, scl_pd_o, sda_pd_o, rx_valid_o and tx_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | 7 | Address the target answers to |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_pd_o | output | 1 | Pull SCL low when high |
| sda_pd_o | output | 1 | Pull SDA low when high |
| rx_data_o | output | 8 | Received data byte |
| rx_valid_o | output | 1 | Received byte is waiting |
| rx_ready_i | input | 1 | Local side takes the received byte |
| rx_full_i | input | 1 | Local side can take no more data; refuse the byte |
| tx_data_i | input | 8 | Byte to send to the controller |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Target is stretching and waiting for a byte to send |

## Verification
The assertions check four properties on every cycle. SDA and the start of SCL stretching move only while SCL is low. A presented byte holds until it is taken. Stretching stays active whenever a byte is pending in either direction. An idle target pulls neither line. Everything else can only be shown by the bench scenarios: which address gets an acknowledge, byte contents in both directions, busy refusal, the end of a read on NACK, repeated START and restart in the middle of a byte. The bench sweeps all 128 addresses, runs byte bursts with several local-side delays, and compares every byte against values it computes itself.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_RX_WAIT,
    ST_WR_ACK,
    ST_WR_NACK,
    ST_TX_WAIT,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_target_sync.sv
module i2c_target_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '1;  // idle bus is high
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '1;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/i2c_target_edges.sv
module i2c_target_edges
  import i2c_target_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_s_i,
  input  logic     sda_s_i,
  output bus_evt_t evt_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  always_comb begin
    evt_o.scl   = scl_s_i;
    evt_o.sda   = sda_s_i;
    evt_o.rise  = scl_s_i & ~scl_q;
    evt_o.fall  = ~scl_s_i & scl_q;
    // SDA edges with SCL high on both samples
    evt_o.start = scl_s_i & scl_q & sda_q & ~sda_s_i;
    evt_o.stop  = scl_s_i & scl_q & ~sda_q & sda_s_i;
  end

endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
  import i2c_target_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              rx_full_i,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              scl_pd_o,
  output logic              sda_pd_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_ready_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              rw_q;
  logic              ack_q;
  logic              byte_end;

  assign byte_end   = evt_i.fall && (cnt_q == LAST_BIT);
  assign tx_ready_o = (state_q == ST_TX_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      ack_q      <= 1'b0;
      scl_pd_o   <= 1'b0;
      sda_pd_o   <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else if (evt_i.start || evt_i.stop) begin
      state_q    <= evt_i.start ? ST_ADDR : ST_IDLE;
      cnt_q      <= '0;
      scl_pd_o   <= 1'b0;
      sda_pd_o   <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (evt_i.rise) begin
            sh_q  <= {sh_q[DATA_W-2:0], evt_i.sda};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end) begin
            if (sh_q[DATA_W-1:1] == own_addr_i) begin
              sda_pd_o <= 1'b1;
              rw_q     <= sh_q[0];
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt_i.fall) begin
            sda_pd_o <= 1'b0;
            cnt_q    <= '0;
            if (rw_q) begin
              scl_pd_o <= 1'b1;
              state_q  <= ST_TX_WAIT;
            end else begin
              state_q  <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (evt_i.rise) begin
            sh_q  <= {sh_q[DATA_W-2:0], evt_i.sda};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end) begin
            if (rx_full_i) begin
              state_q    <= ST_WR_NACK;
            end else begin
              rx_data_o  <= sh_q;
              rx_valid_o <= 1'b1;
              scl_pd_o   <= 1'b1;
              state_q    <= ST_RX_WAIT;
            end
          end
        end
        ST_RX_WAIT: begin
          if (rx_ready_i) begin
            rx_valid_o <= 1'b0;
            scl_pd_o   <= 1'b0;
            sda_pd_o   <= 1'b1;
            state_q    <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (evt_i.fall) begin
            sda_pd_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WR_BYTE;
          end
        end
        ST_WR_NACK: begin
          if (evt_i.fall) state_q <= ST_IDLE;
        end
        ST_TX_WAIT: begin
          if (tx_valid_i) begin
            sh_q     <= tx_data_i;
            sda_pd_o <= ~tx_data_i[DATA_W-1];
            scl_pd_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_RD_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (evt_i.rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_end) begin
            sda_pd_o <= 1'b0;  // controller owns the ack slot
            state_q  <= ST_RD_ACK;
          end else if (evt_i.fall) begin
            sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
            sda_pd_o <= ~sh_q[DATA_W-2];
          end
        end
        ST_RD_ACK: begin
          if (evt_i.rise) begin
            ack_q <= ~evt_i.sda;
          end else if (evt_i.fall) begin
            if (ack_q) begin
              scl_pd_o <= 1'b1;
              state_q  <= ST_TX_WAIT;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  sda_move_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pd_o != $past(sda_pd_o)) |-> !$past(evt_i.scl));

  // R9
  stretch_begin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_pd_o && !$past(scl_pd_o)) |-> !$past(evt_i.scl));

  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i && !evt_i.start && !evt_i.stop)
      |=> (rx_valid_o && $stable(rx_data_o)));

  // R4
  rx_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> scl_pd_o);

  // R7
  tx_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (scl_pd_o && !rx_valid_o));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sda_pd_o && !scl_pd_o && !tx_ready_o));

endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2c_target_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pd_o,
  output logic              sda_pd_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              rx_full_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);

  logic [1:0] line_s;
  bus_evt_t   evt;

  i2c_target_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  i2c_target_edges u_edges (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_s_i (line_s[1]),
    .sda_s_i (line_s[0]),
    .evt_o   (evt)
  );

  i2c_target_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .own_addr_i (own_addr_i),
    .rx_full_i  (rx_full_i),
    .rx_ready_i (rx_ready_i),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .scl_pd_o   (scl_pd_o),
    .sda_pd_o   (sda_pd_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .tx_ready_o (tx_ready_o)
  );

endmodule

// File: tb/i2c_target_bench.sv
module i2c_target_bench;

  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_c = 1'b1, sda_c = 1'b1;
  logic scl_pd, sda_pd;
  logic scl_bus, sda_bus;
  assign scl_bus = scl_c & ~scl_pd;
  assign sda_bus = sda_c & ~sda_pd;

  logic [7:0] rx_data;
  logic       rx_valid, tx_ready;
  logic       rx_ready = 1'b0, rx_full = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data;

  int checks = 0, fails = 0;
  int rx_cnt = 0, rx_delay = 1, rx_wait = 0;
  logic [7:0] rx_log [64];
  int tx_idx = 0, tx_delay = 1, tx_wait = 0;
  int stretch_cyc = 0, r9_viol = 0;
  logic scl_prev = 1'b1, sda_pd_prev = 1'b0;

  function automatic logic [7:0] tx_byte(input int idx);
    return 8'((idx * 29) + 3);
  endfunction

  assign tx_data = tx_byte(tx_idx);

  i2c_target u_i2c_target (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .own_addr_i (OWN),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_pd_o   (scl_pd),
    .sda_pd_o   (sda_pd),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .rx_ready_i (rx_ready),
    .rx_full_i  (rx_full),
    .tx_data_i  (tx_data),
    .tx_valid_i (tx_valid),
    .tx_ready_o (tx_ready)
  );

  // local side models
  always @(negedge clk) begin
    if (rx_ready) begin
      rx_ready = 1'b0;
      rx_wait  = 0;
    end else if (rx_valid) begin
      if (rx_wait >= rx_delay) begin
        rx_ready = 1'b1;
        rx_log[rx_cnt % 64] = rx_data;
        rx_cnt++;
      end else rx_wait++;
    end
    if (tx_valid) begin
      tx_valid = 1'b0;
      tx_idx++;
      tx_wait  = 0;
    end else if (tx_ready) begin
      if (tx_wait >= tx_delay) tx_valid = 1'b1;
      else tx_wait++;
    end
    if (scl_c && !scl_bus) stretch_cyc++;
    if (scl_bus && scl_prev && (sda_pd != sda_pd_prev)) r9_viol++;
    scl_prev    = scl_bus;
    sda_pd_prev = sda_pd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; wait_q();
    scl_c = 1'b1; wait_scl_high(); wait_q();
    sda_c = 1'b0; wait_q();
    scl_c = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; wait_q();
    scl_c = 1'b1; wait_scl_high(); wait_q();
    sda_c = 1'b1; wait_q();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_c = b; wait_q();
    scl_c = 1'b1; wait_scl_high(); wait_q();
    r = sda_bus;
    scl_c = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clock_bit(~give_ack, r);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic ack, ack2, r;
    logic [7:0] d;
    int base, n0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!scl_pd && !sda_pd && !rx_valid && !tx_ready, "R11 reset outputs",
        {scl_pd, sda_pd, rx_valid, tx_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 / R3 address sweep, each followed by one data byte
    for (int a = 0; a < 128; a++) begin
      logic exp;
      exp = (7'(a) == OWN);
      n0  = rx_cnt;
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk(ack == exp, exp ? "R2 address ack" : "R3 address nack", ack, exp);
      send_byte(8'((a * 3) + 1), ack2);
      chk(ack2 == exp, "R3 data ack after address", ack2, exp);
      chk(rx_cnt == n0 + int'(exp), "R3 bytes presented", rx_cnt, n0 + int'(exp));
      if (exp) chk(rx_log[n0 % 64] == 8'((a * 3) + 1), "R4 received byte",
                   rx_log[n0 % 64], 8'((a * 3) + 1));
      bus_stop();
    end

    // R4 / R10 long write burst with varying local delay
    n0 = rx_cnt;
    stretch_cyc = 0;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk(ack, "R2 write address ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      rx_delay = (i % 6) * 7;
      send_byte(8'((i * 73) + 11), ack);
      chk(ack, "R4 data ack", ack, 1);
      chk(rx_log[(n0 + i) % 64] == 8'((i * 73) + 11), "R10 burst byte",
          rx_log[(n0 + i) % 64], 8'((i * 73) + 11));
    end
    bus_stop();
    chk(rx_cnt == n0 + 16, "R10 burst count", rx_cnt, n0 + 16);
    chk(stretch_cyc >= 35, "R4 SCL stretched while local side busy", stretch_cyc, 35);
    rx_delay = 1;

    // R6 busy NACK on first data byte
    n0 = rx_cnt;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk(ack, "R6 address ack before busy", ack, 1);
    rx_full = 1'b1;
    send_byte(8'hC3, ack);
    chk(!ack, "R6 busy nack", ack, 0);
    chk(rx_cnt == n0, "R6 refused byte not presented", rx_cnt, n0);
    rx_full = 1'b0;
    send_byte(8'h3C, ack);
    chk(!ack && rx_cnt == n0, "R6 idle after busy nack", rx_cnt, n0);
    bus_stop();

    // R7 / R8 read burst
    base = tx_idx;
    stretch_cyc = 0;
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < 6; i++) begin
      tx_delay = i * 5;
      recv_byte(i != 5, d);
      chk(d == tx_byte(base + i), "R7 read byte", d, tx_byte(base + i));
    end
    clock_bit(1'b1, r);
    chk(r == 1'b1, "R8 SDA released after controller nack", r, 1);
    chk(tx_idx == base + 6, "R8 no fetch after nack", tx_idx, base + 6);
    bus_stop();
    chk(stretch_cyc >= 25, "R7 SCL stretched waiting for byte", stretch_cyc, 25);
    tx_delay = 1;

    // R10 repeated START switches direction
    n0 = rx_cnt;
    base = tx_idx;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    send_byte(8'h5C, ack2);
    chk(ack && ack2 && rx_log[n0 % 64] == 8'h5C, "R10 write before restart",
        rx_log[n0 % 64], 8'h5C);
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    chk(ack, "R10 read address after restart", ack, 1);
    recv_byte(1'b0, d);
    chk(d == tx_byte(base), "R10 read after restart", d, tx_byte(base));
    bus_stop();

    // R1 START in the middle of a byte restarts the bit count
    n0 = rx_cnt;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    clock_bit(1'b1, r);
    clock_bit(1'b0, r);
    clock_bit(1'b1, r);
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk(ack, "R1 address after mid-byte start", ack, 1);
    send_byte(8'hA7, ack);
    chk(ack && rx_cnt == n0 + 1 && rx_log[n0 % 64] == 8'hA7, "R1 byte after restart",
        rx_log[n0 % 64], 8'hA7);
    bus_stop();
    repeat (8) @(negedge clk);
    chk(!scl_pd && !sda_pd && !tx_ready && !rx_valid, "R1 lines released after STOP",
        {scl_pd, sda_pd, tx_ready, rx_valid}, 0);

    chk(r9_viol == 0, "R9 SDA pull-down moved while SCL high", r9_viol, 0);
    summary();
    $finish;
  end

endmodule